// File: doc/BRIEF.md
# Paged Register Port for an LED Matrix Controller

This block is the host-facing register port of an LED matrix controller. A host reaches it over a four-wire SPI link in mode 0, with the clock idling low and data captured on the rising edge. Every transaction opens with a command byte, which carries the direction, a fixed chip identity and a page number. An address byte follows, then any number of data bytes. The address steps forward by one after each data byte, in both directions. There are three pages. Page 0 holds per-dot duty bytes, page 1 holds per-dot current scaling bytes, and page 2 holds the function registers.

The SPI pins are sampled in the block's own clock domain through a synchroniser, so SCK must run several times slower than `clk`. The scan logic reads the per-dot pages through a combinational lookup port. The function registers appear on dedicated output buses. Open/short detection results come in from outside through a valid-qualified status port. That port has no ready signal and applies no back-pressure: every cycle with `os_valid` high is taken. A key value written to the reset register returns every register to its power-up value.

Top module: `lmx_regport`

## Requirements
- R1: While `spi_csn` is low, the block assembles a byte from eight `spi_mosi` bits, taken MSB first on rising `spi_sck` edges. A falling `spi_csn` starts a new transaction at the command byte.
- R2: The command byte is laid out as follows: bit 7 = 1 selects a read and 0 a write; bits 6:4 must be 3'b101; bits 3:0 give the page, which must be 0, 1 or 2. Any other command causes all later bytes to be ignored until `spi_csn` rises, and `spi_miso_oe` stays low for that time.
- R3: The second byte sets the register address. Each later data byte uses the current address, which then increments by one, wrapping at 8 bits. This holds for writes and for reads.
- R4: Pages 0 and 1 hold one byte per dot at addresses 01h to C6h, each resetting to 00h. `scan_val` shows the byte selected by `scan_page` and `scan_idx`. On these pages, writes to other addresses are dropped and reads of them return 00h.
- R5: Page 2 holds five writable function registers, each driven on its own output: 00h on `cfg_reg` (reset 08h), 01h on `gcc_reg` (reset 00h), 02h on `pull_reg` (reset 33h), 24h on `therm_reg` (reset 00h) and 25h on `sprd_reg` (reset 00h).
- R6: Page 2 addresses 03h to 23h read back detection results. A cycle with `os_valid` high stores `os_data` (6 bits) at address 03h + `os_idx`; bits 7:6 read as 0. SPI writes to these addresses are dropped.
- R7: Writing AEh to page 2 address 2Fh restores every register to its reset value, including the detection results. Writing any other value there has no effect, and 2Fh reads as 00h.
- R8: In a read, `spi_miso` presents each register MSB first and changes only after a falling `spi_sck`. The first bit appears after the falling edge that follows the address byte. `spi_miso_oe` is high while `spi_csn` is low and the command was accepted, and low while `spi_csn` is high.
- R9: Page 2 addresses outside those named in R5, R6 and R7 read as 00h and drop writes.
- R10: If `spi_csn` rises partway through a byte, that partial byte is dropped. Bytes completed before it in the same transaction still take effect.
- R11: The status port accepts a new entry on every cycle, including back-to-back cycles with `os_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad; low means high impedance |
| os_valid | input | 1 | Detection result valid |
| os_idx | input | 6 | Result slot, 0 to 32 |
| os_data | input | 6 | Result bits for one slot |
| scan_page | input | 2 | Lookup page (0 or 1) |
| scan_idx | input | 8 | Lookup dot address |
| scan_val | output | 8 | Looked-up dot byte |
| cfg_reg | output | 8 | Configuration register |
| gcc_reg | output | 8 | Global current register |
| pull_reg | output | 8 | Pull resistor select register |
| therm_reg | output | 8 | Thermal setting register |
| sprd_reg | output | 8 | Spread spectrum / sync register |

## Verification
The assertions assume that SCK half-periods span several `clk` cycles. Under that assumption a byte-complete pulse never coincides with a falling SCK edge, and each synchronised edge is seen exactly once. The stimulus holds every SCK level and every chip-select setup and hold for eight clocks. It does not drive `os_valid` in the same cycle as an SPI write to the detection-result addresses. A behavioural model of the three pages is held in the bench. It is compared against the function-register outputs on every idle clock and against every byte read back over MISO.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_ADDR, ST_DATA, ST_IGN} lmx_st_e;
  localparam logic [1:0] PG_DUTY  = 2'd0;
  localparam logic [1:0] PG_SCALE = 2'd1;
  localparam logic [1:0] PG_FUNC  = 2'd2;
  localparam logic [7:0] A_CFG    = 8'h00;
  localparam logic [7:0] A_GCC    = 8'h01;
  localparam logic [7:0] A_PULL   = 8'h02;
  localparam logic [7:0] A_THERM  = 8'h24;
  localparam logic [7:0] A_SPRD   = 8'h25;
  localparam logic [7:0] A_RST    = 8'h2F;
  localparam logic [7:0] CFG_DEF  = 8'h08;
  localparam logic [7:0] PULL_DEF = 8'h33;
endpackage

// File: rtl/lmx_spi_rx.sv
module lmx_spi_rx #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       csn,
  input  logic       mosi,
  output logic       cs_act,
  output logic       sck_fall,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  logic [SYNC-1:0] sck_p, csn_p, mosi_p;
  logic sck_d;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic sck_s, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC-2:0], sck};
      csn_p  <= {csn_p[SYNC-2:0], csn};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
      sck_d  <= sck_p[SYNC-1];
    end
  end

  assign sck_s    = sck_p[SYNC-1];
  assign cs_act   = ~csn_p[SYNC-1];
  assign rise     = sck_s & ~sck_d & cs_act;
  assign sck_fall = ~sck_s & sck_d & cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
    end else if (rise) begin
      shreg    <= {shreg[5:0], mosi_p[SYNC-1]};
      bit_cnt  <= bit_cnt + 3'd1;
      byte_vld <= (bit_cnt == 3'd7);
      byte_dat <= {shreg, mosi_p[SYNC-1]};
    end else begin
      byte_vld <= 1'b0;
    end
  end

  // R1
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(cs_act));
endmodule

// File: rtl/lmx_spi_fsm.sv
module lmx_spi_fsm
  import lmx_pkg::*;
#(
  parameter logic [2:0] CHIP_ID = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sck_fall,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  input  logic [7:0] rd_data,
  output logic [1:0] rd_page,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [1:0] wr_page,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       miso,
  output logic       miso_oe
);
  lmx_st_e    st_q;
  logic       rw_q;
  logic [1:0] page_q;
  logic [7:0] addr_q, tx_q;
  logic       miso_q;
  logic       cmd_ok;

  assign cmd_ok  = (byte_dat[6:4] == CHIP_ID) && (byte_dat[3:0] <= 4'd2);
  assign rd_page = page_q;
  assign rd_addr = (st_q == ST_ADDR) ? byte_dat : addr_q + 8'd1;
  assign wr_en   = byte_vld && (st_q == ST_DATA) && !rw_q;
  assign wr_page = page_q;
  assign wr_addr = addr_q;
  assign wr_data = byte_dat;
  assign miso    = miso_q;
  assign miso_oe = cs_act && (st_q != ST_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      rw_q   <= 1'b0;
      page_q <= '0;
      addr_q <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act) begin
      st_q   <= ST_CMD;
      miso_q <= 1'b0;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_CMD: begin
          st_q   <= cmd_ok ? ST_ADDR : ST_IGN;
          rw_q   <= byte_dat[7];
          page_q <= byte_dat[1:0];
        end
        ST_ADDR: begin
          addr_q <= byte_dat;
          tx_q   <= rd_data;
          st_q   <= ST_DATA;
        end
        ST_DATA: begin
          addr_q <= addr_q + 8'd1;
          tx_q   <= rd_data;
        end
        default: st_q <= ST_IGN;
      endcase
    end else if (sck_fall && st_q == ST_DATA && rw_q) begin
      miso_q <= tx_q[7];
      tx_q   <= {tx_q[6:0], 1'b0};
    end
  end

  // R2
  bad_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && cs_act && st_q == ST_CMD && !cmd_ok) |=> (st_q == ST_IGN && !miso_oe));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && cs_act && st_q == ST_DATA) |=> addr_q == $past(addr_q) + 8'd1);
endmodule

// File: rtl/lmx_regbank.sv
module lmx_regbank
  import lmx_pkg::*;
#(
  parameter int         DOTS    = 198,
  parameter int         OS_N    = 33,
  parameter int         OS_W    = 6,
  parameter logic [7:0] OS_BASE = 8'h03,
  parameter logic [7:0] RST_KEY = 8'hAE,
  localparam int        DIW     = $clog2(DOTS),
  localparam int        OIW     = $clog2(OS_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_page,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      rd_page,
  input  logic [7:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic [1:0]      sc_page,
  input  logic [7:0]      sc_idx,
  output logic [7:0]      sc_val,
  input  logic            os_valid,
  input  logic [OIW-1:0]  os_idx,
  input  logic [OS_W-1:0] os_data,
  output logic [7:0]      cfg_q,
  output logic [7:0]      gcc_q,
  output logic [7:0]      pull_q,
  output logic [7:0]      therm_q,
  output logic [7:0]      sprd_q
);
  logic [7:0]      duty_m  [DOTS];
  logic [7:0]      scale_m [DOTS];
  logic [OS_W-1:0] os_m    [OS_N];
  logic            soft_rst;
  logic [7:0]      wi;

  function automatic logic is_dot(input logic [7:0] a);
    return (a >= 8'd1) && (int'(a) <= DOTS);
  endfunction

  function automatic logic is_os(input logic [7:0] a);
    return (a >= OS_BASE) && (int'(a) < int'(OS_BASE) + OS_N);
  endfunction

  function automatic logic [7:0] peek(input logic [1:0] pg, input logic [7:0] a);
    logic [7:0] di, oi;
    di = a - 8'd1;
    oi = a - OS_BASE;
    peek = '0;
    if (pg == PG_DUTY && is_dot(a))       peek = duty_m[di[DIW-1:0]];
    else if (pg == PG_SCALE && is_dot(a)) peek = scale_m[di[DIW-1:0]];
    else if (pg == PG_FUNC) begin
      if (is_os(a))           peek = 8'(os_m[oi[OIW-1:0]]);
      else if (a == A_CFG)    peek = cfg_q;
      else if (a == A_GCC)    peek = gcc_q;
      else if (a == A_PULL)   peek = pull_q;
      else if (a == A_THERM)  peek = therm_q;
      else if (a == A_SPRD)   peek = sprd_q;
    end
  endfunction

  assign rd_data  = peek(rd_page, rd_addr);
  assign sc_val   = (sc_page == PG_FUNC) ? 8'h00 : peek(sc_page, sc_idx);
  assign soft_rst = wr_en && wr_page == PG_FUNC && wr_addr == A_RST && wr_data == RST_KEY;
  assign wi       = wr_addr - 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DOTS; i++) begin
        duty_m[i]  <= '0;
        scale_m[i] <= '0;
      end
      for (int j = 0; j < OS_N; j++) os_m[j] <= '0;
      cfg_q <= CFG_DEF; gcc_q <= '0; pull_q <= PULL_DEF; therm_q <= '0; sprd_q <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < DOTS; i++) begin
        duty_m[i]  <= '0;
        scale_m[i] <= '0;
      end
      for (int j = 0; j < OS_N; j++) os_m[j] <= '0;
      cfg_q <= CFG_DEF; gcc_q <= '0; pull_q <= PULL_DEF; therm_q <= '0; sprd_q <= '0;
    end else begin
      if (os_valid && int'(os_idx) < OS_N) os_m[os_idx] <= os_data;
      if (wr_en) begin
        if (wr_page == PG_DUTY && is_dot(wr_addr))  duty_m[wi[DIW-1:0]]  <= wr_data;
        if (wr_page == PG_SCALE && is_dot(wr_addr)) scale_m[wi[DIW-1:0]] <= wr_data;
        if (wr_page == PG_FUNC) begin
          if (wr_addr == A_CFG)   cfg_q   <= wr_data;
          if (wr_addr == A_GCC)   gcc_q   <= wr_data;
          if (wr_addr == A_PULL)  pull_q  <= wr_data;
          if (wr_addr == A_THERM) therm_q <= wr_data;
          if (wr_addr == A_SPRD)  sprd_q  <= wr_data;
        end
      end
    end
  end

  // R7
  soft_reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_q == CFG_DEF && pull_q == PULL_DEF && gcc_q == 8'h00));
  // R6
  status_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_page == PG_FUNC && wr_addr == OS_BASE && !os_valid) |=> $stable(os_m[0]));
endmodule

// File: rtl/lmx_regport.sv
module lmx_regport #(
  parameter int         DOTS    = 198,
  parameter int         OS_N    = 33,
  parameter int         OS_W    = 6,
  parameter int         SYNC    = 2,
  parameter logic [2:0] CHIP_ID = 3'b101,
  parameter logic [7:0] RST_KEY = 8'hAE,
  localparam int        OIW     = $clog2(OS_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_sck,
  input  logic            spi_csn,
  input  logic            spi_mosi,
  output logic            spi_miso,
  output logic            spi_miso_oe,
  input  logic            os_valid,
  input  logic [OIW-1:0]  os_idx,
  input  logic [OS_W-1:0] os_data,
  input  logic [1:0]      scan_page,
  input  logic [7:0]      scan_idx,
  output logic [7:0]      scan_val,
  output logic [7:0]      cfg_reg,
  output logic [7:0]      gcc_reg,
  output logic [7:0]      pull_reg,
  output logic [7:0]      therm_reg,
  output logic [7:0]      sprd_reg
);
  logic       cs_act, sck_fall, byte_vld, wr_en;
  logic [7:0] byte_dat, rd_data, rd_addr, wr_addr, wr_data;
  logic [1:0] rd_page, wr_page;

  lmx_spi_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .cs_act(cs_act), .sck_fall(sck_fall), .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  lmx_spi_fsm #(.CHIP_ID(CHIP_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .rd_data(rd_data),
    .rd_page(rd_page), .rd_addr(rd_addr), .wr_en(wr_en), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_data(wr_data), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  lmx_regbank #(.DOTS(DOTS), .OS_N(OS_N), .OS_W(OS_W), .RST_KEY(RST_KEY)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_page(rd_page), .rd_addr(rd_addr), .rd_data(rd_data),
    .sc_page(scan_page), .sc_idx(scan_idx), .sc_val(scan_val),
    .os_valid(os_valid), .os_idx(os_idx), .os_data(os_data),
    .cfg_q(cfg_reg), .gcc_q(gcc_reg), .pull_q(pull_reg), .therm_q(therm_reg), .sprd_q(sprd_reg)
  );
endmodule

// File: tb/lmx_regport_bench.sv
`timescale 1ns/1ps
module lmx_regport_bench;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0;
  logic sck = 0, csn = 1, mosi = 0;
  logic miso, miso_oe;
  logic os_valid = 0;
  logic [5:0] os_idx = 0, os_data = 0;
  logic [1:0] scan_page = 0;
  logic [7:0] scan_idx = 0;
  logic [7:0] scan_val, cfg_reg, gcc_reg, pull_reg, therm_reg, sprd_reg;

  int checks = 0, errors = 0, idle_cnt = 0, oe_hi = 0, oe_lo = 0;
  bit done = 0;
  logic [7:0] m0 [256], m1 [256], m2 [256];
  logic [7:0] txq[$], rxq[$];

  always #10 clk = ~clk;

  lmx_regport u_lmx_regport (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .os_valid(os_valid), .os_idx(os_idx),
    .os_data(os_data), .scan_page(scan_page), .scan_idx(scan_idx), .scan_val(scan_val),
    .cfg_reg(cfg_reg), .gcc_reg(gcc_reg), .pull_reg(pull_reg), .therm_reg(therm_reg),
    .sprd_reg(sprd_reg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void mdl_defaults();
    for (int i = 0; i < 256; i++) begin m0[i] = 0; m1[i] = 0; m2[i] = 0; end
    m2[8'h00] = 8'h08;
    m2[8'h02] = 8'h33;
  endfunction

  function automatic logic [7:0] mdl_read(input int pg, input logic [7:0] a);
    if (pg == 0) return (a >= 1 && a <= 198) ? m0[a] : 8'h00;
    if (pg == 1) return (a >= 1 && a <= 198) ? m1[a] : 8'h00;
    if (a <= 8'h25) return m2[a];
    return 8'h00;
  endfunction

  function automatic void mdl_write(input int pg, input logic [7:0] a, input logic [7:0] d);
    if (pg == 0 && a >= 1 && a <= 198) m0[a] = d;
    if (pg == 1 && a >= 1 && a <= 198) m1[a] = d;
    if (pg == 2) begin
      if (a == 8'h00 || a == 8'h01 || a == 8'h02 || a == 8'h24 || a == 8'h25) m2[a] = d;
      if (a == 8'h2F && d == 8'hAE) mdl_defaults();
    end
  endfunction

  function automatic void mdl_apply(input int cut);
    int full;
    logic [7:0] a;
    if (txq.size() < 2) return;
    if (txq[0][6:4] != 3'b101 || txq[0][3:0] > 2 || txq[0][7]) return;
    full = txq.size() - ((cut < 8) ? 1 : 0);
    a = txq[1];
    for (int i = 2; i < full; i++) begin
      mdl_write(int'(txq[0][1:0]), a, txq[i]);
      a = a + 8'd1;
    end
  endfunction

  // cut: number of bits clocked in the final byte (8 = complete)
  task automatic spi_run(input int cut);
    logic [7:0] r;
    int nb, nbits;
    nb = txq.size();
    rxq = {}; oe_hi = 0; oe_lo = 0;
    @(negedge clk); csn = 0; idle_cnt = 0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      nbits = (b == nb - 1) ? cut : 8;
      r = 0;
      for (int k = 7; k > 7 - nbits; k--) begin
        mosi = txq[b][k];
        repeat (HALF) @(negedge clk);
        r[k] = miso;
        if (miso_oe) oe_hi++; else oe_lo++;
        sck = 1;
        repeat (HALF) @(negedge clk);
        sck = 0;
      end
      rxq.push_back(r);
    end
    repeat (HALF) @(negedge clk);
    csn = 1;
    mdl_apply(cut);
    repeat (12) @(negedge clk);
  endtask

  task automatic spi_read_check(input string req, input int pg, input logic [7:0] a, input int n);
    txq = {8'h80 | 8'h50 | 8'(pg), a};
    for (int i = 0; i < n; i++) txq.push_back(8'h00);
    spi_run(8);
    for (int i = 0; i < n; i++) chk(req, rxq[i+2], mdl_read(pg, a + 8'(i)));
    chk({req, " oe"}, 8'(oe_lo), 8'd0);
  endtask

  task automatic scan_check(input string req, input int pg, input logic [7:0] a);
    @(negedge clk); scan_page = 2'(pg); scan_idx = a;
    @(negedge clk); chk(req, scan_val, mdl_read(pg, a));
  endtask

  task automatic status_put(input int idx, input logic [5:0] d);
    os_valid = 1; os_idx = 6'(idx); os_data = d;
    m2[8'h03 + 8'(idx)] = {2'b00, d};
    @(negedge clk);
  endtask

  // every-clock comparison of function registers against the model while idle (R5)
  always @(negedge clk) begin
    if (rst_n && csn) idle_cnt++;
    if (rst_n && csn && idle_cnt > 6 && !done) begin
      checks++;
      if ({cfg_reg, gcc_reg, pull_reg, therm_reg, sprd_reg} !==
          {m2[8'h00], m2[8'h01], m2[8'h02], m2[8'h24], m2[8'h25]} || miso_oe !== 1'b0) begin
        errors++;
        $display("FAIL R5/R8 idle: actual %h %h %h %h %h oe %b expected %h %h %h %h %h oe 0",
          cfg_reg, gcc_reg, pull_reg, therm_reg, sprd_reg, miso_oe,
          m2[8'h00], m2[8'h01], m2[8'h02], m2[8'h24], m2[8'h25]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mdl_defaults();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state (R5, R4, R8)
    chk("R5 cfg reset", cfg_reg, 8'h08);
    chk("R5 pull reset", pull_reg, 8'h33);
    chk("R8 oe idle", {7'd0, miso_oe}, 8'h00);
    scan_check("R4 reset dot", 0, 8'd5);

    // R1 R3: burst write to page 0
    txq = {8'h50, 8'h01, 8'hAA, 8'hBB, 8'hCC}; spi_run(8);
    scan_check("R3 burst 1", 0, 8'h01);
    scan_check("R3 burst 2", 0, 8'h02);
    scan_check("R1 burst 3", 0, 8'h03);

    // R4: page 1 edge C6 and beyond
    txq = {8'h51, 8'hC6, 8'h5A, 8'h77}; spi_run(8);
    scan_check("R4 last dot", 1, 8'hC6);
    scan_check("R4 beyond dots", 1, 8'hC7);
    spi_read_check("R4 R8 read edge", 1, 8'hC5, 3);

    // R5 function registers
    txq = {8'h52, 8'h00, 8'h0B, 8'h40, 8'h00}; spi_run(8);
    txq = {8'h52, 8'h24, 8'h09, 8'hD5}; spi_run(8);
    chk("R5 gcc", gcc_reg, 8'h40);
    chk("R5 therm", therm_reg, 8'h09);
    spi_read_check("R5 R8 read func", 2, 8'h00, 3);

    // R6 R11 status port, back-to-back, then SPI write dropped
    @(negedge clk);
    status_put(0, 6'h3F);
    status_put(32, 6'h15);
    os_valid = 0;
    txq = {8'h52, 8'h03, 8'h11}; spi_run(8);
    spi_read_check("R6 R11 status read", 2, 8'h03, 1);
    spi_read_check("R6 R11 status last", 2, 8'h23, 1);

    // R9 unmapped page 2
    txq = {8'h52, 8'h26, 8'h99}; spi_run(8);
    spi_read_check("R9 unmapped read", 2, 8'h26, 2);

    // R2 bad chip id and bad page
    txq = {8'h30, 8'h01, 8'h77}; spi_run(8);
    chk("R2 bad id oe", 8'(oe_hi > 8 ? 1 : 0), 8'd0);
    scan_check("R2 bad id no write", 0, 8'h01);
    txq = {8'hD3, 8'h01, 8'h00}; spi_run(8);
    chk("R2 bad page oe", 8'(oe_hi > 8 ? 1 : 0), 8'd0);

    // R10 abort mid-byte
    txq = {8'h50, 8'h10, 8'h44, 8'hFF}; spi_run(4);
    scan_check("R10 full byte kept", 0, 8'h10);
    scan_check("R10 partial dropped", 0, 8'h11);

    // R3 address wrap on read
    spi_read_check("R3 wrap read", 0, 8'hFF, 3);

    // R7: non-key value ignored, then key resets
    txq = {8'h52, 8'h2F, 8'h12}; spi_run(8);
    chk("R7 non-key", gcc_reg, 8'h40);
    spi_read_check("R7 reads zero", 2, 8'h2F, 1);
    txq = {8'h52, 8'h2F, 8'hAE}; spi_run(8);
    mdl_defaults();
    chk("R7 cfg default", cfg_reg, 8'h08);
    chk("R7 gcc default", gcc_reg, 8'h00);
    scan_check("R7 dot cleared", 0, 8'h02);
    spi_read_check("R7 status cleared", 2, 8'h03, 1);

    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule